// File: doc/BRIEF.md
# Physical Memory Type Resolver

This block decides the effective caching behaviour of one physical access. A lookup brings a physical address and three attribute bits taken from the page mapping. The block derives a range type from the physical address and a page type from the attribute bits, combines the two so that the stricter one wins, and returns the result one clock after the request. A global cache-disable input forces the answer to uncacheable.

The range type has three sources, tried in order. The first megabyte of address space is split into 88 fixed slots of decreasing size. Above that, a bank of base/mask windows applies. An address that no slot or window covers gets a programmable default. The page type comes from an 8-entry table indexed by the three page bits. Every table entry is loaded through a single write port. A write lands at the clock edge, so a lookup in the following cycle already sees it.

Top module: `memtype_resolver`

## Requirements
- R1: `rsp_vld` is high in exactly the cycles that follow a cycle with `req_vld` high, and `rsp_type` then carries the answer for that request.
- R2: Below address 0x100000 the fixed table supplies the range type. Slots 0-7 are 64 KB each from 0x00000, slots 8-23 are 16 KB each from 0x80000, and slots 24-87 are 4 KB each from 0xC0000. A slot is written with `wr_kind`=0, `wr_idx`=slot, and `wr_type`=type.
- R3: Where a fixed slot and a variable window both cover an address, the fixed slot's type is used.
- R4: A variable window i matches when its valid bit is set and (addr & mask) == (base & mask). The base and type are written with `wr_kind`=1. The mask is written with `wr_kind`=2, with the valid bit taken from `wr_type[0]`. A window with its valid bit clear never matches.
- R5: When several windows match: UC wins over everything; if all matching types are identical, that type is used; a mix of only WT and WB gives WT; any other mix gives UC.
- R6: An address at or above 0x100000 that matches no window takes the default type. The default is written with `wr_kind`=3, `wr_idx`=8.
- R7: The page type is entry PAT*4+PCD*2+PWT of the page table. Entries are written with `wr_kind`=3, `wr_idx`=0..7.
- R8: After reset: the page entries hold WB, WT, UC-, UC, WB, WT, UC-, UC; every fixed slot holds UC; the default is UC; no window is valid; `rsp_vld` is 0.
- R9: The merge works as follows. A range type of UC- or of codes 2 or 3 counts as UC, and a page code of 2 or 3 counts as UC. If either side is UC, the result is UC. If the page is UC-, the result is WC when the range is WC and UC otherwise. Otherwise the stricter of the two types wins, in the order UC > WC > WT > WP > WB.
- R10: With `cache_dis` high at the request, the result is UC.
- R11: Type codes are UC=0, WC=1, WT=4, WP=5, WB=6, UC-=7. The output is always one of 0, 1, 4, 5 or 6.
- R12: A table write in cycle N affects a lookup requested in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | Write target: 0 fixed slot, 1 window base+type, 2 window mask+valid, 3 page entry / default |
| wr_idx | input | 7 | Slot, window or entry index |
| wr_data | input | 36 | Base or mask value |
| wr_type | input | 3 | Type code (valid bit in bit 0 for masks) |
| req_vld | input | 1 | Lookup request |
| req_addr | input | 36 | Physical address |
| req_pat | input | 1 | Page attribute index bit 2 |
| req_pcd | input | 1 | Page attribute index bit 1 |
| req_pwt | input | 1 | Page attribute index bit 0 |
| cache_dis | input | 1 | Global cache disable |
| rsp_vld | output | 1 | Response valid |
| rsp_type | output | 3 | Effective memory type |

## Verification
All 88 fixed slots are loaded with a rotating set of types and probed at their first and last byte, so any misplaced slot boundary lands in a neighbouring slot with a different type. Every range code, including the unused codes and UC-, is paired with every page code through the default and page tables, which covers the whole merge table. Overlapping window setups separate the multi-match outcomes: UC dominance, an identical pair, a WT/WB pair, an incompatible pair, an invalid window and fixed-over-window precedence. The reset page contents are read back under two different default types, which makes UC- and UC distinguishable.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
  localparam logic [2:0] MT_UC  = 3'd0;
  localparam logic [2:0] MT_WC  = 3'd1;
  localparam logic [2:0] MT_WT  = 3'd4;
  localparam logic [2:0] MT_WP  = 3'd5;
  localparam logic [2:0] MT_WB  = 3'd6;
  localparam logic [2:0] MT_UCM = 3'd7;

  localparam logic [1:0] WK_FIX  = 2'd0;
  localparam logic [1:0] WK_BASE = 2'd1;
  localparam logic [1:0] WK_MASK = 2'd2;
  localparam logic [1:0] WK_MISC = 2'd3;

  localparam int N64K = 8;
  localparam int N16K = 16;
  localparam int N4K  = 64;
  localparam int FIX_N = N64K + N16K + N4K;
  localparam int PG_N  = 8;
  localparam int DEF_SLOT = PG_N;

  // slot number of an address inside the first megabyte
  function automatic logic [6:0] fix_index(input logic [19:0] a);
    if (!a[19])      return {4'd0, a[18:16]};
    else if (!a[18]) return 7'(N64K) + {3'd0, a[17:14]};
    else             return 7'(N64K + N16K) + {1'b0, a[17:12]};
  endfunction

  function automatic logic [2:0] norm_range(input logic [2:0] t);
    case (t)
      MT_WC, MT_WT, MT_WP, MT_WB: return t;
      default:                    return MT_UC;
    endcase
  endfunction

  function automatic logic [2:0] norm_page(input logic [2:0] t);
    case (t)
      MT_WC, MT_WT, MT_WP, MT_WB, MT_UCM: return t;
      default:                            return MT_UC;
    endcase
  endfunction

  function automatic logic [2:0] merge_types(input logic [2:0] rng, input logic [2:0] pg);
    logic [2:0] r, p;
    r = norm_range(rng);
    p = norm_page(pg);
    if (r == MT_UC || p == MT_UC)  return MT_UC;
    if (p == MT_UCM)               return (r == MT_WC) ? MT_WC : MT_UC;
    if (r == MT_WC || p == MT_WC)  return MT_WC;
    if (r == MT_WT || p == MT_WT)  return MT_WT;
    if (r == MT_WP || p == MT_WP)  return MT_WP;
    return MT_WB;
  endfunction

  function automatic logic [2:0] pg_reset(input logic [1:0] k);
    case (k)
      2'd0:    return MT_WB;
      2'd1:    return MT_WT;
      2'd2:    return MT_UCM;
      default: return MT_UC;
    endcase
  endfunction
endpackage

// File: rtl/mt_fixed_tbl.sv
module mt_fixed_tbl
  import memtype_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_type,
  input  logic [PA_W-1:0]  addr,
  output logic             hit,
  output logic [2:0]       typ
);
  logic [2:0] slot_q [FIX_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FIX_N; i++) slot_q[i] <= MT_UC;
    end else if (wr_en && (wr_idx < IDX_W'(FIX_N))) begin
      slot_q[wr_idx] <= wr_type;
    end
  end

  assign hit = (addr[PA_W-1:20] == '0);
  assign typ = slot_q[fix_index(addr[19:0])];
endmodule

// File: rtl/mt_var_bank.sv
module mt_var_bank
  import memtype_pkg::*;
#(
  parameter int PA_W = 36,
  parameter int NVAR = 8,
  localparam int VIDX_W = (NVAR > 1) ? $clog2(NVAR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base_en,
  input  logic              wr_mask_en,
  input  logic [VIDX_W-1:0] wr_idx,
  input  logic [PA_W-1:0]   wr_data,
  input  logic [2:0]        wr_type,
  input  logic [PA_W-1:0]   addr,
  output logic              hit,
  output logic [2:0]        typ
);
  logic [NVAR-1:0] match;
  logic [2:0]      win_type [NVAR];

  for (genvar g = 0; g < NVAR; g++) begin : g_win
    logic [PA_W-1:0] base_q, mask_q;
    logic            vld_q;
    logic [2:0]      type_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        vld_q  <= 1'b0;
        type_q <= MT_UC;
      end else begin
        if (wr_base_en && wr_idx == VIDX_W'(g)) begin
          base_q <= wr_data;
          type_q <= wr_type;
        end
        if (wr_mask_en && wr_idx == VIDX_W'(g)) begin
          mask_q <= wr_data;
          vld_q  <= wr_type[0];
        end
      end
    end
    assign match[g]    = vld_q && ((addr & mask_q) == (base_q & mask_q));
    assign win_type[g] = type_q;
  end

  always_comb begin
    logic       seen, conflict, has_uc, has_odd;
    logic [2:0] first;
    seen = 1'b0; conflict = 1'b0; has_uc = 1'b0; has_odd = 1'b0;
    first = MT_UC;
    for (int i = 0; i < NVAR; i++) begin
      if (match[i]) begin
        if (!seen) first = win_type[i];
        else if (win_type[i] != first) conflict = 1'b1;
        seen = 1'b1;
        if (norm_range(win_type[i]) == MT_UC) has_uc = 1'b1;
        if (win_type[i] != MT_WT && win_type[i] != MT_WB) has_odd = 1'b1;
      end
    end
    if (has_uc)         typ = MT_UC;
    else if (!conflict) typ = norm_range(first);
    else if (!has_odd)  typ = MT_WT;
    else                typ = MT_UC;
  end

  assign hit = |match;
endmodule

// File: rtl/mt_attr_regs.sv
module mt_attr_regs
  import memtype_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_type,
  input  logic [2:0]       pidx,
  output logic [2:0]       pg_type,
  output logic [2:0]       def_type
);
  logic [2:0] pg_q [PG_N];
  logic [2:0] def_q;

  for (genvar g = 0; g < PG_N; g++) begin : g_pg
    always_ff @(posedge clk) begin
      if (!rst_n) pg_q[g] <= pg_reset(2'(g % 4));
      else if (wr_en && wr_idx == IDX_W'(g)) pg_q[g] <= wr_type;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) def_q <= MT_UC;
    else if (wr_en && wr_idx == IDX_W'(DEF_SLOT)) def_q <= wr_type;
  end

  assign pg_type  = pg_q[pidx];
  assign def_type = def_q;
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import memtype_pkg::*;
#(
  parameter int PA_W = 36,
  parameter int NVAR = 8,
  localparam int IDX_W  = $clog2(FIX_N),
  localparam int VIDX_W = (NVAR > 1) ? $clog2(NVAR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_data,
  input  logic [2:0]       wr_type,
  input  logic             req_vld,
  input  logic [PA_W-1:0]  req_addr,
  input  logic             req_pat,
  input  logic             req_pcd,
  input  logic             req_pwt,
  input  logic             cache_dis,
  output logic             rsp_vld,
  output logic [2:0]       rsp_type
);
  logic       fix_hit, var_hit, var_sel_ok;
  logic [2:0] fix_type, var_type, def_type, pg_type, rng_type, eff_type;

  assign var_sel_ok = (wr_idx < IDX_W'(NVAR));

  mt_fixed_tbl #(.PA_W(PA_W), .IDX_W(IDX_W)) i_fix (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_kind == WK_FIX), .wr_idx(wr_idx), .wr_type(wr_type),
    .addr(req_addr), .hit(fix_hit), .typ(fix_type)
  );

  mt_var_bank #(.PA_W(PA_W), .NVAR(NVAR)) i_var (
    .clk(clk), .rst_n(rst_n),
    .wr_base_en(wr_en && wr_kind == WK_BASE && var_sel_ok),
    .wr_mask_en(wr_en && wr_kind == WK_MASK && var_sel_ok),
    .wr_idx(wr_idx[VIDX_W-1:0]), .wr_data(wr_data), .wr_type(wr_type),
    .addr(req_addr), .hit(var_hit), .typ(var_type)
  );

  mt_attr_regs #(.IDX_W(IDX_W)) i_attr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_kind == WK_MISC), .wr_idx(wr_idx), .wr_type(wr_type),
    .pidx({req_pat, req_pcd, req_pwt}),
    .pg_type(pg_type), .def_type(def_type)
  );

  // fixed slots first, then windows, then the default
  assign rng_type = fix_hit ? fix_type : (var_hit ? var_type : def_type);
  assign eff_type = cache_dis ? MT_UC : merge_types(rng_type, pg_type);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_type <= MT_UC;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) rsp_type <= eff_type;
    end
  end
endmodule

// File: rtl/memtype_resolver_chk.sv
module memtype_resolver_chk
  import memtype_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_vld,
  input logic       cache_dis,
  input logic       rsp_vld,
  input logic [2:0] rsp_type,
  input logic       fix_hit,
  input logic [2:0] fix_type,
  input logic [2:0] rng_type,
  input logic [2:0] pg_type
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  a_r10_cd_uc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && cache_dis) |=> rsp_type == MT_UC);
  a_r3_fixed_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fix_hit |-> rng_type == fix_type);
  a_r11_legal_out: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_type == MT_UC || rsp_type == MT_WC || rsp_type == MT_WT ||
                 rsp_type == MT_WP || rsp_type == MT_WB));
  a_r9_page_uc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && pg_type == MT_UC) |=> rsp_type == MT_UC);
  a_r9_wb_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !cache_dis && pg_type == MT_WB && rng_type == MT_WB) |=> rsp_type == MT_WB);
endmodule

bind memtype_resolver memtype_resolver_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .cache_dis(cache_dis),
  .rsp_vld(rsp_vld), .rsp_type(rsp_type), .fix_hit(fix_hit),
  .fix_type(fix_type), .rng_type(rng_type), .pg_type(pg_type)
);

// File: tb/test_memtype_resolver.sv
module test_memtype_resolver;
  localparam int AW = 36;
  localparam logic [AW-1:0] ONES = {AW{1'b1}};
  localparam logic [2:0] UC = 3'd0, WC = 3'd1, WT = 3'd4, WP = 3'd5, WB = 3'd6, UCM = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [6:0] wr_idx = '0;
  logic [AW-1:0] wr_data = '0;
  logic [2:0] wr_type = '0;
  logic req_vld = 1'b0, req_pat = 1'b0, req_pcd = 1'b0, req_pwt = 1'b0, cache_dis = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_vld;
  logic [2:0] rsp_type;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  memtype_resolver i_memtype_resolver (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_type(wr_type), .req_vld(req_vld), .req_addr(req_addr),
    .req_pat(req_pat), .req_pcd(req_pcd), .req_pwt(req_pwt), .cache_dis(cache_dis),
    .rsp_vld(rsp_vld), .rsp_type(rsp_type)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input int idx, input logic [AW-1:0] d, input logic [2:0] t);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = 7'(idx); wr_data = d; wr_type = t;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a, input int pidx, input bit cd, output logic [2:0] t);
    @(negedge clk);
    req_vld = 1'b1; req_addr = a; {req_pat, req_pcd, req_pwt} = 3'(pidx); cache_dis = cd;
    @(negedge clk);
    req_vld = 1'b0; cache_dis = 1'b0;
    check("R1 rsp_vld", int'(rsp_vld), 1);
    t = rsp_type;
  endtask

  // stricter-wins model built from a rank
  function automatic int rank(input logic [2:0] t);
    case (t)
      UC: return 4; WC: return 3; WT: return 2; WP: return 1; default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] model(input logic [2:0] r, input logic [2:0] p);
    logic [2:0] rr, pp;
    rr = (r == WC || r == WT || r == WP || r == WB) ? r : UC;
    pp = (p == WC || p == WT || p == WP || p == WB || p == UCM) ? p : UC;
    if (pp == UCM) return (rr == WC) ? WC : UC;
    return (rank(rr) >= rank(pp)) ? rr : pp;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] t;
    logic [2:0] rot [5];
    logic [2:0] exp_wb [4];
    logic [2:0] exp_wc [4];
    rot = '{UC, WC, WT, WP, WB};
    exp_wb = '{WB, WT, UC, UC};
    exp_wc = '{WC, WC, WC, UC};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 rsp_vld after reset", int'(rsp_vld), 0);

    // R8: fixed slots reset to UC
    wr(2'd3, 8, '0, WB);
    look(36'h0, 0, 0, t); check("R8 fixed reset UC", t, UC);
    // R8/R7: reset page entries read through two defaults
    for (int p = 0; p < 8; p++) begin
      look(36'h2000000, p, 0, t); check("R8 page reset (def WB)", t, exp_wb[p % 4]);
    end
    wr(2'd3, 8, '0, WC);
    for (int p = 0; p < 8; p++) begin
      look(36'h2000000, p, 0, t); check("R8 page reset (def WC)", t, exp_wc[p % 4]);
    end

    // R9/R7/R11: every range code against every page code
    for (int r = 0; r < 8; r++) begin
      wr(2'd3, 8, '0, 3'(r));
      for (int p = 0; p < 8; p++) begin
        wr(2'd3, p, '0, 3'(p));
        look(36'h3000000, p, 0, t); check("R9 merge table", t, model(3'(r), 3'(p)));
      end
    end
    wr(2'd3, 0, '0, WB);
    wr(2'd3, 8, '0, WB);

    // R2: all fixed slots, first and last byte
    for (int i = 0; i < 88; i++) wr(2'd0, i, '0, rot[i % 5]);
    for (int i = 0; i < 88; i++) begin
      longint b, s;
      if (i < 8)       begin b = 64'h10000 * i;             s = 64'h10000; end
      else if (i < 24) begin b = 64'h80000 + 64'h4000 * (i - 8);  s = 64'h4000; end
      else             begin b = 64'hC0000 + 64'h1000 * (i - 24); s = 64'h1000; end
      look(AW'(b), 0, 0, t);         check("R2 fixed slot start", t, rot[i % 5]);
      look(AW'(b + s - 1), 0, 0, t); check("R2 fixed slot end", t, rot[i % 5]);
    end
    look(36'h100000, 0, 0, t); check("R6 above fixed region -> default", t, WB);

    // R4: single window
    wr(2'd1, 0, 36'h100000, WT); wr(2'd2, 0, ONES << 20, 3'd1);
    look(36'h180000, 0, 0, t); check("R4 window match", t, WT);
    look(36'h200000, 0, 0, t); check("R6 no window -> default", t, WB);
    // R5: WT with WB
    wr(2'd1, 1, 36'h100000, WB); wr(2'd2, 1, ONES << 21, 3'd1);
    look(36'h180000, 0, 0, t); check("R5 WT+WB -> WT", t, WT);
    // R5: UC dominates
    wr(2'd1, 2, 36'h180000, UC); wr(2'd2, 2, ONES << 19, 3'd1);
    look(36'h180000, 0, 0, t); check("R5 UC wins", t, UC);
    look(36'h100000, 0, 0, t); check("R4 mask excludes window", t, WT);
    // R5: identical pair, then incompatible
    wr(2'd1, 3, 36'h400000, WC); wr(2'd2, 3, ONES << 20, 3'd1);
    wr(2'd1, 4, 36'h400000, WC); wr(2'd2, 4, ONES << 20, 3'd1);
    look(36'h400000, 0, 0, t); check("R5 identical types", t, WC);
    wr(2'd1, 5, 36'h400000, WP); wr(2'd2, 5, ONES << 20, 3'd1);
    look(36'h400000, 0, 0, t); check("R5 WC+WP -> UC", t, UC);
    // R4: valid bit
    wr(2'd1, 6, 36'h800000, UC); wr(2'd2, 6, ONES << 20, 3'd0);
    look(36'h800000, 0, 0, t); check("R4 invalid window ignored", t, WB);
    wr(2'd2, 6, ONES << 20, 3'd1);
    look(36'h800000, 0, 0, t); check("R4 window made valid", t, UC);
    // R3: catch-all window vs fixed slot
    wr(2'd0, 0, '0, WB);
    wr(2'd1, 7, '0, WT); wr(2'd2, 7, '0, 3'd1);
    look(36'h1000, 0, 0, t); check("R3 fixed beats window", t, WB);
    look(36'h900000, 0, 0, t); check("R4 zero mask matches all", t, WT);

    // R10
    look(36'h1000, 0, 1, t); check("R10 cache_dis on fixed", t, UC);
    look(36'h900000, 0, 1, t); check("R10 cache_dis on window", t, UC);

    // R12: write then lookup on the very next cycle
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 7'd1; wr_type = WT;
    @(negedge clk);
    wr_en = 1'b0; req_vld = 1'b1; req_addr = 36'h10000; {req_pat, req_pcd, req_pwt} = 3'd0;
    @(negedge clk);
    req_vld = 1'b0;
    check("R12 write seen next cycle", int'(rsp_type), WT);
    @(negedge clk);
    check("R1 no request -> rsp_vld low", int'(rsp_vld), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule